// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit core's memory stage and a word-wide, byte-addressed data memory. Each cycle the core may present one request: an operation code, a base register value, a signed 16-bit displacement and, for stores, the store data. In the same cycle the unit forms the effective address. It then drives the word address, per-lane byte write enables and lane-replicated write data towards the memory. Any access that is not naturally aligned for its size is flagged.

Lanes are numbered in big-endian order. The byte at the lowest address of a word is the most significant byte. The memory returns the addressed word one clock after the request. The unit remembers the size and lane offset of each accepted load and, in that following cycle, turns the returned word into a 32-bit result. Byte and halfword results are sign-extended.

Top module: `lsu_be_align`

## Requirements
- R1: The effective address is base_addr plus the sign-extended 16-bit offset (range -32768 to +32767). mem_word_addr is bits 31:2 of that sum, driven combinationally in the request cycle.
- R2: req_op codes: 0 load word, 1 load halfword, 2 load byte, 3 store word, 4 store halfword, 5 store byte. Codes 6 and 7, or req_valid low, cause no write enable, no error and no load_valid.
- R3: An aligned store word drives mem_byte_we = 4'b1111 and mem_wdata = store_data.
- R4: Lanes are big-endian. mem_byte_we[3] covers bits 31:24, which hold the byte at word offset 0. mem_byte_we[3-k] covers offset k. A store byte at offset k asserts only bit 3-k, and mem_wdata carries store_data[7:0] in all four lanes.
- R5: A store halfword at offset 0 drives mem_byte_we = 4'b1100, and at offset 2 it drives 4'b0011. In both cases mem_wdata carries store_data[15:0] in both halves.
- R6: A word access with address bits 1:0 not 00, or a halfword access with address bit 0 set, raises misalign_err in the request cycle. Such an access drives mem_byte_we = 0 and produces no load_valid. Byte accesses are never misaligned.
- R7: For an aligned load, load_valid is high in the cycle after the request, and only then. A load word returns mem_rdata of that cycle unchanged.
- R8: A load halfword returns bits 31:16 of the word for offset 0 and bits 15:0 for offset 2, sign-extended to 32 bits.
- R9: A load byte at offset k returns bits (31-8k) down to (24-8k), sign-extended to 32 bits.
- R10: After reset, and whenever load_valid is low, load_result is zero.
- R11: The load result is formed only from state captured with the load. A new request in the return cycle, including a store to the same word, does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Data for stores, taken from the low bits |
| mem_word_addr | output | 30 | Word address to memory |
| mem_byte_we | output | 4 | Byte-lane write enables, bit 3 = most significant lane |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Word returned by memory one cycle after the request |
| misalign_err | output | 1 | Current request is misaligned |
| load_valid | output | 1 | load_result is valid |
| load_result | output | 32 | Aligned, sign-extended load data |

## Verification
Two things can fall in the same cycle: the return of a load issued one cycle earlier and the issue of a new request, including a store to the very word being returned. The bench issues a load and then, in the next cycle, a store of new data to the same address. The load result sampled in that cycle must be the word as it stood before the store. A second load must then return the new data. Misaligned stores are checked the same way: a later load must show that the memory word is unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN    = 32;
  localparam int NBYTES  = XLEN / 8;
  localparam int LANE_W  = $clog2(NBYTES);
  localparam int IMM_W   = 16;
  localparam int WADDR_W = XLEN - LANE_W;

  typedef enum logic [2:0] {
    OP_LW = 3'd0,
    OP_LH = 3'd1,
    OP_LB = 3'd2,
    OP_SW = 3'd3,
    OP_SH = 3'd4,
    OP_SB = 3'd5,
    OP_N6 = 3'd6,
    OP_N7 = 3'd7
  } mem_op_e;

  function automatic logic [XLEN-1:0] eff_addr(logic [XLEN-1:0] base, logic [IMM_W-1:0] imm);
    return base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic [2:0] op_size(mem_op_e op);
    case (op)
      OP_LW, OP_SW: return 3'd4;
      OP_LH, OP_SH: return 3'd2;
      OP_LB, OP_SB: return 3'd1;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic logic op_is_load(mem_op_e op);
    return (op == OP_LW) || (op == OP_LH) || (op == OP_LB);
  endfunction

  function automatic logic op_is_store(mem_op_e op);
    return (op == OP_SW) || (op == OP_SH) || (op == OP_SB);
  endfunction

  // Offset bits below the access size must be zero
  function automatic logic misaligned(logic [2:0] sz, logic [LANE_W-1:0] ln);
    logic [LANE_W-1:0] m;
    m = LANE_W'(sz - 3'd1);
    return (sz != 3'd0) && ((ln & m) != '0);
  endfunction

  // Byte at word offset i is driven by enable bit NBYTES-1-i
  function automatic logic [NBYTES-1:0] lane_mask(logic [2:0] sz, logic [LANE_W-1:0] ln);
    logic [NBYTES-1:0] m;
    m = '0;
    for (int i = 0; i < NBYTES; i++)
      if (i >= int'(ln) && i < int'(ln) + int'(sz)) m[NBYTES-1-i] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] replicate(logic [XLEN-1:0] d, logic [2:0] sz);
    case (sz)
      3'd1:    return {NBYTES{d[7:0]}};
      3'd2:    return {(NBYTES/2){d[15:0]}};
      default: return d;
    endcase
  endfunction

  // Move the addressed item to the top, then sign-extend it downwards
  function automatic logic [XLEN-1:0] extract_load(logic [XLEN-1:0] w, logic [2:0] sz,
                                                    logic [LANE_W-1:0] ln);
    logic [XLEN-1:0] t;
    t = w << {ln, 3'b000};
    case (sz)
      3'd1:    return {{(XLEN-8){t[XLEN-1]}}, t[XLEN-1 -: 8]};
      3'd2:    return {{(XLEN-16){t[XLEN-1]}}, t[XLEN-1 -: 16]};
      default: return t;
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic                req_valid,
  input  mem_op_e             op,
  input  logic [XLEN-1:0]     base,
  input  logic [IMM_W-1:0]    imm,
  output logic [WADDR_W-1:0]  word_addr,
  output logic [LANE_W-1:0]   lane,
  output logic [2:0]          size,
  output logic                err
);
  logic [XLEN-1:0] ea;

  always_comb begin
    ea        = eff_addr(base, imm);
    word_addr = ea[XLEN-1:LANE_W];
    lane      = ea[LANE_W-1:0];
    size      = req_valid ? op_size(op) : 3'd0;
    err       = misaligned(size, lane);
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic                req_valid,
  input  mem_op_e             op,
  input  logic [2:0]          size,
  input  logic [LANE_W-1:0]   lane,
  input  logic                err,
  input  logic [XLEN-1:0]     wr_data,
  output logic [NBYTES-1:0]   byte_we,
  output logic [XLEN-1:0]     wdata
);
  logic              wr_fire;
  logic [NBYTES-1:0] mask;

  assign wr_fire = req_valid && op_is_store(op) && !err;
  assign mask    = lane_mask(size, lane);
  assign wdata   = replicate(wr_data, size);

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign byte_we[g] = wr_fire && mask[g];
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_fire,
  input  logic [2:0]         size,
  input  logic [LANE_W-1:0]  lane,
  input  logic [XLEN-1:0]    rdata,
  output logic               ld_valid,
  output logic [XLEN-1:0]    ld_result
);
  logic              q_valid;
  logic [2:0]        q_size;
  logic [LANE_W-1:0] q_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_size  <= 3'd0;
      q_lane  <= '0;
    end else begin
      q_valid <= rd_fire;
      if (rd_fire) begin
        q_size <= size;
        q_lane <= lane;
      end
    end
  end

  assign ld_valid  = q_valid;
  assign ld_result = q_valid ? extract_load(rdata, q_size, q_lane) : '0;

  // R7
  ld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(rd_fire));

  // R9
  ld_byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && q_size == 3'd1) |-> (ld_result[XLEN-1:8] == {(XLEN-8){ld_result[7]}}));

  // R8
  ld_half_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && q_size == 3'd2) |-> (ld_result[XLEN-1:16] == {(XLEN-16){ld_result[15]}}));
endmodule

// File: rtl/lsu_be_align.sv
module lsu_be_align
  import lsu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [XLEN-1:0]      base_addr,
  input  logic [IMM_W-1:0]     offset,
  input  logic [XLEN-1:0]      store_data,
  output logic [WADDR_W-1:0]   mem_word_addr,
  output logic [NBYTES-1:0]    mem_byte_we,
  output logic [XLEN-1:0]      mem_wdata,
  input  logic [XLEN-1:0]      mem_rdata,
  output logic                 misalign_err,
  output logic                 load_valid,
  output logic [XLEN-1:0]      load_result
);
  mem_op_e           op;
  logic [LANE_W-1:0] lane;
  logic [2:0]        size;
  logic              rd_fire;

  assign op = mem_op_e'(req_op);

  lsu_addr_gen u_addr (
    .req_valid (req_valid),
    .op        (op),
    .base      (base_addr),
    .imm       (offset),
    .word_addr (mem_word_addr),
    .lane      (lane),
    .size      (size),
    .err       (misalign_err)
  );

  lsu_store_lanes u_store (
    .req_valid (req_valid),
    .op        (op),
    .size      (size),
    .lane      (lane),
    .err       (misalign_err),
    .wr_data   (store_data),
    .byte_we   (mem_byte_we),
    .wdata     (mem_wdata)
  );

  assign rd_fire = req_valid && op_is_load(op) && !misalign_err;

  lsu_load_align u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .size      (size),
    .lane      (lane),
    .rdata     (mem_rdata),
    .ld_valid  (load_valid),
    .ld_result (load_result)
  );

  // R6
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> (mem_byte_we == '0));

  // R6
  no_load_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |=> !load_valid);

  // R4
  we_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_byte_we) == 0) || ($countones(mem_byte_we) == 1) ||
    ($countones(mem_byte_we) == 2) || ($countones(mem_byte_we) == NBYTES));

  // R3
  sw_full_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_SW && !misalign_err) |-> (mem_byte_we == '1));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_byte_we == '0 && !misalign_err));

  // R10
  result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_valid |-> (load_result == '0));
endmodule

// File: tb/test_lsu_be_align.sv
module test_lsu_be_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] base_addr = '0;
  logic [15:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [29:0] mem_word_addr;
  logic [3:0]  mem_byte_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign_err;
  logic        load_valid;
  logic [31:0] load_result;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lsu_be_align i_lsu_be_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base_addr(base_addr), .offset(offset), .store_data(store_data),
    .mem_word_addr(mem_word_addr), .mem_byte_we(mem_byte_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .misalign_err(misalign_err),
    .load_valid(load_valid), .load_result(load_result)
  );

  // Memory model: registered read of the old word, byte-lane writes, bit 3 = MS lane
  logic [31:0] mem [16];
  always @(posedge clk) begin
    mem_rdata <= mem[mem_word_addr[3:0]];
    for (int j = 0; j < 4; j++)
      if (mem_byte_we[j]) mem[mem_word_addr[3:0]][8*j +: 8] <= mem_wdata[8*j +: 8];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [2:0] op, logic [31:0] b, logic [15:0] o, logic [31:0] d);
    @(negedge clk);
    req_valid = v; req_op = op; base_addr = b; offset = o; store_data = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic store(logic [2:0] op, logic [31:0] b, logic [15:0] o, logic [31:0] d,
                       logic [3:0] exp_we, logic [31:0] exp_wd, string tag);
    drive(1'b1, op, b, o, d);
    chk({tag, " we"}, {28'd0, mem_byte_we}, {28'd0, exp_we});
    chk({tag, " wdata"}, mem_wdata, exp_wd);
    chk({tag, " err"}, {31'd0, misalign_err}, 32'd0);
    idle();
  endtask

  task automatic load(logic [2:0] op, logic [31:0] b, logic [15:0] o, logic [31:0] exp, string tag);
    drive(1'b1, op, b, o, 32'd0);
    chk({tag, " err"}, {31'd0, misalign_err}, 32'd0);
    chk({tag, " no write"}, {28'd0, mem_byte_we}, 32'd0);
    idle();
    chk({tag, " valid"}, {31'd0, load_valid}, 32'd1);
    chk({tag, " result"}, load_result, exp);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", {31'd0, load_valid}, 32'd0);
    chk("R10 reset result", load_result, 32'd0);
  endtask

  task automatic t_word();
    store(3'd3, 32'h0000_0100, 16'h0008, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, "R3 sw");
    drive(1'b1, 3'd0, 32'h0000_0100, 16'h0008, 32'd0);
    chk("R1 word addr", {2'b00, mem_word_addr}, 32'h0000_0042);
    idle();
    chk("R7 lw result", load_result, 32'hCAFE_F00D);
    drive(1'b1, 3'd3, 32'h0000_0200, 16'hFFFC, 32'h0BAD_BEEF);
    chk("R1 negative offset addr", {2'b00, mem_word_addr}, 32'h0000_007F);
    idle();
    load(3'd0, 32'h0000_01F0, 16'h000C, 32'h0BAD_BEEF, "R1 lw via other base");
  endtask

  task automatic t_half();
    store(3'd3, 32'h0, 16'h0010, 32'h8001_7FFE, 4'b1111, 32'h8001_7FFE, "R3 sw half base");
    load(3'd1, 32'h0, 16'h0010, 32'hFFFF_8001, "R8 lh off0");
    load(3'd1, 32'h0, 16'h0012, 32'h0000_7FFE, "R8 lh off2");
    store(3'd4, 32'h0, 16'h0012, 32'hFFFF_1234, 4'b0011, 32'h1234_1234, "R5 sh off2");
    store(3'd4, 32'h0, 16'h0014, 32'h0000_5678, 4'b1100, 32'h5678_5678, "R5 sh off0");
    load(3'd0, 32'h0, 16'h0010, 32'h8001_1234, "R5 lw after sh");
  endtask

  task automatic t_byte();
    store(3'd3, 32'h0, 16'h0020, 32'h12F0_7F80, 4'b1111, 32'h12F0_7F80, "R3 sw byte base");
    load(3'd2, 32'h0, 16'h0020, 32'h0000_0012, "R9 lb off0");
    load(3'd2, 32'h0, 16'h0021, 32'hFFFF_FFF0, "R9 lb off1");
    load(3'd2, 32'h0, 16'h0022, 32'h0000_007F, "R9 lb off2");
    load(3'd2, 32'h0, 16'h0023, 32'hFFFF_FF80, "R9 lb off3");
    store(3'd5, 32'h0, 16'h0021, 32'h0000_00AB, 4'b0100, 32'hABAB_ABAB, "R4 sb off1");
    store(3'd5, 32'h0, 16'h0023, 32'h0000_00CD, 4'b0001, 32'hCDCD_CDCD, "R4 sb off3");
    load(3'd0, 32'h0, 16'h0020, 32'h12AB_7FCD, "R4 lw after sb");
  endtask

  task automatic t_misalign();
    store(3'd3, 32'h0, 16'h0030, 32'h1111_2222, 4'b1111, 32'h1111_2222, "R3 sw mis base");
    drive(1'b1, 3'd3, 32'h0, 16'h0031, 32'hDEAD_DEAD);
    chk("R6 sw mis err", {31'd0, misalign_err}, 32'd1);
    chk("R6 sw mis we", {28'd0, mem_byte_we}, 32'd0);
    drive(1'b1, 3'd4, 32'h0, 16'h0033, 32'hDEAD_DEAD);
    chk("R6 sh mis err", {31'd0, misalign_err}, 32'd1);
    chk("R6 sh mis we", {28'd0, mem_byte_we}, 32'd0);
    drive(1'b1, 3'd0, 32'h0, 16'h0032, 32'd0);
    chk("R6 lw mis err", {31'd0, misalign_err}, 32'd1);
    idle();
    chk("R6 lw mis no valid", {31'd0, load_valid}, 32'd0);
    drive(1'b1, 3'd1, 32'h0, 16'h0031, 32'd0);
    chk("R6 lh mis err", {31'd0, misalign_err}, 32'd1);
    idle();
    chk("R6 lh mis no valid", {31'd0, load_valid}, 32'd0);
    load(3'd2, 32'h0, 16'h0033, 32'h0000_0022, "R6 lb any offset");
    load(3'd0, 32'h0, 16'h0030, 32'h1111_2222, "R6 memory untouched");
  endtask

  task automatic t_idle_ops();
    drive(1'b1, 3'd6, 32'h0, 16'h0030, 32'hFFFF_FFFF);
    chk("R2 op6 we", {28'd0, mem_byte_we}, 32'd0);
    chk("R2 op6 err", {31'd0, misalign_err}, 32'd0);
    drive(1'b1, 3'd7, 32'h0, 16'h0031, 32'hFFFF_FFFF);
    chk("R2 op7 we", {28'd0, mem_byte_we}, 32'd0);
    chk("R2 op7 err", {31'd0, misalign_err}, 32'd0);
    chk("R2 op6 no valid", {31'd0, load_valid}, 32'd0);
    drive(1'b0, 3'd3, 32'h0, 16'h0030, 32'hFFFF_FFFF);
    chk("R2 invalid no write", {28'd0, mem_byte_we}, 32'd0);
    chk("R2 op7 no valid", {31'd0, load_valid}, 32'd0);
    idle();
    load(3'd0, 32'h0, 16'h0030, 32'h1111_2222, "R2 memory untouched");
  endtask

  task automatic t_overlap();
    drive(1'b1, 3'd0, 32'h0, 16'h0030, 32'd0);
    drive(1'b1, 3'd3, 32'h0, 16'h0030, 32'h5555_AAAA);
    chk("R11 return valid during store", {31'd0, load_valid}, 32'd1);
    chk("R11 old data returned", load_result, 32'h1111_2222);
    chk("R11 store we", {28'd0, mem_byte_we}, 32'h0000_000F);
    drive(1'b1, 3'd2, 32'h0, 16'h0031, 32'd0);
    chk("R11 no valid after store", {31'd0, load_valid}, 32'd0);
    drive(1'b1, 3'd1, 32'h0, 16'h0032, 32'd0);
    chk("R11 back-to-back lb", load_result, 32'h0000_0055);
    idle();
    chk("R8 back-to-back lh", load_result, 32'hFFFF_AAAA);
    idle();
    chk("R10 idle result zero", load_result, 32'd0);
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = 32'd0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_word();
    t_half();
    t_byte();
    t_misalign();
    t_idle_ops();
    t_overlap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule